// File: doc/BRIEF.md
# Event Status and Dual Interrupt Unit

This block collects event indications from the command and data engines of a card host controller into one status word and turns that word into two interrupt lines. The low eleven bits of the word are sticky: a one-cycle pulse on an event input sets the bit, and it stays set until software writes a one to it through the clear register. The upper eleven bits are not stored events. They follow a set of live flag inputs (command in progress and the transmit/receive FIFO level flags), one clock late, and a clear write cannot touch them.

Each interrupt line has its own mask register. A line is high whenever any status bit selected by its mask is set, so one line can serve completion events and the other FIFO level events while both read the same status word. Software reaches the status word, the clear register, both masks and an eight-word identification window through a simple register port with a registered read data path.

Top module: `evt_status_irq`

## Requirements
- R1: Interrupt line i equals the OR of (status AND mask i), registered: it reflects the status and mask values one clock after they change.
- R2: A write to offset 0x038 clears each sticky status bit 10:0 whose written data bit is 1; written bits 31:11 have no effect.
- R3: Status bits 21:11 equal the live flag inputs 10:0 (bit 11 from input bit 0), delayed by one clock, and a clear write never changes them.
- R4: A pulse on event input bit b sets status bit b for b in 0 to 10 except 9; bit 9 is reserved, ignores its input and always reads 0.
- R5: When an event pulse and a clear of the same bit arrive in the same cycle, the bit ends up set.
- R6: Reads return data on the cycle after the read strobe: offset 0x034 gives the status word, 0x03C gives mask 0 and 0x040 gives mask 1 (each mask holds 22 bits, written from data bits 21:0), and 0x038 reads as 0.
- R7: Word-aligned reads at offsets 0xFE0 to 0xFFC return, in order of rising address, the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in data bits 7:0.
- R8: Synchronous reset clears the status word, both masks, both interrupt lines and the read data.
- R9: Reads of any other offset, including non-word-aligned ones, return 0, and writes to them change neither status nor masks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_set | input | 11 | One-cycle set pulses for sticky status bits 10:0 |
| live_flags | input | 11 | Live command/FIFO flags mirrored into status bits 21:11 |
| reg_wr_en | input | 1 | Register write strobe |
| reg_rd_en | input | 1 | Register read strobe |
| reg_addr | input | 12 | Byte offset of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid the cycle after the read strobe |
| irq_out | output | 2 | Masked interrupt lines 0 and 1 |

## Verification
On every cycle the assertions check that a clear write leaves no unprotected sticky bit set, that a set pulse always wins over a simultaneous clear, that the live part of the status word tracks its inputs with exactly one clock of delay, and that each interrupt line equals the masked OR of the previous cycle's status and mask. Only the bench scenarios show the register map at the ports: the offset decode and readback, the identification bytes, the reserved bit 9, the ignored upper clear bits and unmapped offsets, and the per-bit behaviour of both masks swept over every status position.

// File: rtl/msi_pkg.sv
package msi_pkg;

  localparam int STICKY_W = 11;
  localparam int LIVE_W   = 11;
  localparam int NUM_IRQ  = 2;
  localparam int ADDR_W   = 12;
  localparam int DATA_W   = 32;

  // Sticky bit 9 is reserved and never sets.
  localparam logic [STICKY_W-1:0] STICKY_VALID = 11'h5FF;

  localparam logic [ADDR_W-1:0] OFS_STATUS    = 12'h034;
  localparam logic [ADDR_W-1:0] OFS_CLEAR     = 12'h038;
  localparam logic [ADDR_W-1:0] OFS_MASK_BASE = 12'h03C;
  localparam logic [ADDR_W-1:0] OFS_ID_BASE   = 12'hFE0;

  // Identification byte for word index 0..7 of the ID window.
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    logic [7:0] b;
    case (idx)
      3'd0:    b = 8'h81;
      3'd1:    b = 8'h11;
      3'd2:    b = 8'h04;
      3'd3:    b = 8'h00;
      3'd4:    b = 8'h0D;
      3'd5:    b = 8'hF0;
      3'd6:    b = 8'h05;
      default: b = 8'hB1;
    endcase
    return b;
  endfunction

endpackage

// File: rtl/msi_status_reg.sv
module msi_status_reg #(
  parameter int STICKY_W = msi_pkg::STICKY_W,
  parameter int LIVE_W   = msi_pkg::LIVE_W,
  parameter logic [STICKY_W-1:0] VALID = msi_pkg::STICKY_VALID,
  localparam int STATUS_W = STICKY_W + LIVE_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STICKY_W-1:0] evt_set,
  input  logic                clr_en,
  input  logic [STICKY_W-1:0] clr_bits,
  input  logic [LIVE_W-1:0]   live_in,
  output logic [STATUS_W-1:0] status
);

  logic [STICKY_W-1:0] sticky_q;
  logic [STICKY_W-1:0] sticky_d;
  logic [LIVE_W-1:0]   live_q;
  logic [STICKY_W-1:0] clr_eff;

  always_comb begin
    clr_eff  = clr_en ? clr_bits : '0;
    // Set pulses are OR-ed in after the clear, so a set wins.
    sticky_d = (sticky_q & ~clr_eff) | (evt_set & VALID);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sticky_q <= '0;
      live_q   <= '0;
    end else begin
      sticky_q <= sticky_d;
      live_q   <= live_in;
    end
  end

  assign status = {live_q, sticky_q};

  // R2: after a clear, no cleared bit (without a same-cycle set) survives
  assert_w1c_clear_R2: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((sticky_q & $past(clr_bits & ~evt_set)) == '0))
    else $error("clear write left a bit set");

  // R5: a set pulse always lands, even against a clear
  assert_set_wins_R5: assert property (@(posedge clk) disable iff (rst)
    (|(evt_set & VALID)) |=> ((sticky_q & $past(evt_set & VALID)) == $past(evt_set & VALID)))
    else $error("set pulse lost");

  // R3: live bits follow inputs one cycle late
  assert_live_mirror_R3: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (live_q == $past(live_in)))
    else $error("live flags not mirrored");

endmodule

// File: rtl/msi_irq_lane.sv
module msi_irq_lane #(
  parameter int STATUS_W = msi_pkg::STICKY_W + msi_pkg::LIVE_W,
  parameter int DATA_W   = msi_pkg::DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                mask_we,
  input  logic [DATA_W-1:0]   wdata,
  input  logic [STATUS_W-1:0] status,
  output logic [STATUS_W-1:0] mask_q,
  output logic                irq_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (mask_we) mask_q <= wdata[STATUS_W-1:0];
      irq_q <= |(status & mask_q);
    end
  end

  // R1: interrupt equals masked status of the previous cycle
  assert_irq_masked_R1: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (irq_q == (|($past(status) & $past(mask_q)))))
    else $error("interrupt line does not match masked status");

endmodule

// File: rtl/msi_regport.sv
module msi_regport #(
  parameter int STICKY_W = msi_pkg::STICKY_W,
  parameter int STATUS_W = msi_pkg::STICKY_W + msi_pkg::LIVE_W,
  parameter int NUM_IRQ  = msi_pkg::NUM_IRQ,
  parameter int ADDR_W   = msi_pkg::ADDR_W,
  parameter int DATA_W   = msi_pkg::DATA_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic                              rd_en,
  input  logic [ADDR_W-1:0]                 addr,
  input  logic [DATA_W-1:0]                 wdata,
  input  logic [STATUS_W-1:0]               status,
  input  logic [NUM_IRQ-1:0][STATUS_W-1:0]  masks,
  output logic                              clr_en,
  output logic [STICKY_W-1:0]               clr_bits,
  output logic [NUM_IRQ-1:0]                mask_we,
  output logic [DATA_W-1:0]                 rdata
);
  import msi_pkg::*;

  localparam logic [ADDR_W-1:0] ID_HI = OFS_ID_BASE;

  logic [DATA_W-1:0] rd_mux;
  logic [NUM_IRQ-1:0] mask_hit;

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_dec
      localparam logic [ADDR_W-1:0] MASK_OFS = OFS_MASK_BASE + ADDR_W'(4 * gi);
      assign mask_hit[gi] = (addr == MASK_OFS);
      assign mask_we[gi]  = wr_en && mask_hit[gi];
    end
  endgenerate

  assign clr_en   = wr_en && (addr == OFS_CLEAR);
  assign clr_bits = wdata[STICKY_W-1:0];

  always_comb begin
    rd_mux = '0;
    if (addr == OFS_STATUS) rd_mux = DATA_W'(status);
    for (int i = 0; i < NUM_IRQ; i++) begin
      if (mask_hit[i]) rd_mux = DATA_W'(masks[i]);
    end
    if ((addr[ADDR_W-1:5] == ID_HI[ADDR_W-1:5]) && (addr[1:0] == 2'b00))
      rd_mux = DATA_W'(id_byte(addr[4:2]));
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

endmodule

// File: rtl/evt_status_irq.sv
module evt_status_irq #(
  parameter int STICKY_W = msi_pkg::STICKY_W,
  parameter int LIVE_W   = msi_pkg::LIVE_W,
  parameter int NUM_IRQ  = msi_pkg::NUM_IRQ,
  parameter int ADDR_W   = msi_pkg::ADDR_W,
  parameter int DATA_W   = msi_pkg::DATA_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [STICKY_W-1:0] evt_set,
  input  logic [LIVE_W-1:0]   live_flags,
  input  logic                reg_wr_en,
  input  logic                reg_rd_en,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  output logic [NUM_IRQ-1:0]  irq_out
);

  localparam int STATUS_W = STICKY_W + LIVE_W;

  logic [STATUS_W-1:0]              status;
  logic [NUM_IRQ-1:0][STATUS_W-1:0] masks;
  logic                             clr_en;
  logic [STICKY_W-1:0]              clr_bits;
  logic [NUM_IRQ-1:0]               mask_we;

  msi_regport #(
    .STICKY_W(STICKY_W), .STATUS_W(STATUS_W), .NUM_IRQ(NUM_IRQ),
    .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regport (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .rd_en(reg_rd_en),
    .addr(reg_addr), .wdata(reg_wdata), .status(status), .masks(masks),
    .clr_en(clr_en), .clr_bits(clr_bits), .mask_we(mask_we), .rdata(reg_rdata)
  );

  msi_status_reg #(
    .STICKY_W(STICKY_W), .LIVE_W(LIVE_W)
  ) u_status (
    .clk(clk), .rst(rst), .evt_set(evt_set), .clr_en(clr_en),
    .clr_bits(clr_bits), .live_in(live_flags), .status(status)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NUM_IRQ; gi++) begin : g_irq
      msi_irq_lane #(.STATUS_W(STATUS_W), .DATA_W(DATA_W)) u_lane (
        .clk(clk), .rst(rst), .mask_we(mask_we[gi]), .wdata(reg_wdata),
        .status(status), .mask_q(masks[gi]), .irq_q(irq_out[gi])
      );
    end
  endgenerate

endmodule

// File: tb/evt_status_irq_bench.sv
module evt_status_irq_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [10:0] evt_set = '0;
  logic [10:0] live_flags = '0;
  logic        reg_wr_en = 1'b0;
  logic        reg_rd_en = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [1:0]  irq_out;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  evt_status_irq u_evt_status_irq (
    .clk(clk), .rst(rst), .evt_set(evt_set), .live_flags(live_flags),
    .reg_wr_en(reg_wr_en), .reg_rd_en(reg_rd_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_rd_en = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd_en = 1'b0;
    d = reg_rdata;
  endtask

  task automatic pulse(input logic [10:0] v);
    @(negedge clk);
    evt_set = v;
    @(negedge clk);
    evt_set = '0;
  endtask

  initial begin
    logic [31:0] v;
    logic [21:0] pat;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R8: reset state
    check("R8 irq after reset", {30'd0, irq_out}, 32'd0);
    rd(12'h034, v); check("R8 status after reset", v, 32'd0);
    rd(12'h03C, v); check("R8 mask0 after reset", v, 32'd0);
    rd(12'h040, v); check("R8 mask1 after reset", v, 32'd0);

    // R4/R2: sweep each sticky bit, set then clear
    for (int b = 0; b < 11; b++) begin
      pulse(11'(1 << b));
      rd(12'h034, v);
      check(b == 9 ? "R4 reserved bit 9" : "R4 sticky set", v, (b == 9) ? 32'd0 : (32'd1 << b));
      wr(12'h038, 32'(1 << b));
      rd(12'h034, v); check("R2 w1c clear", v, 32'd0);
    end

    // R2: clear only hits written ones
    pulse(11'h0F0);
    wr(12'h038, 32'h0000_0030);
    rd(12'h034, v); check("R2 partial clear", v, 32'h0000_00C0);
    wr(12'h038, 32'hFFFF_FFFF);

    // R3: live bits mirrored and immune to clear
    for (int b = 0; b < 11; b++) begin
      @(negedge clk); live_flags = 11'(1 << b);
      rd(12'h034, v); check("R3 live mirror", v, 32'd1 << (11 + b));
      wr(12'h038, 32'hFFFF_FFFF);
      rd(12'h034, v); check("R3 live not cleared", v, 32'd1 << (11 + b));
    end
    @(negedge clk); live_flags = '0;

    // R5: set beats simultaneous clear
    pulse(11'h018);
    @(negedge clk);
    evt_set = 11'h008; reg_wr_en = 1'b1; reg_addr = 12'h038; reg_wdata = 32'h7FF;
    @(negedge clk);
    evt_set = '0; reg_wr_en = 1'b0;
    rd(12'h034, v); check("R5 set wins over clear", v, 32'h008);
    wr(12'h038, 32'h7FF);

    // R6: mask readback and clear reads as zero
    wr(12'h03C, 32'hFFFF_FFFF);
    rd(12'h03C, v); check("R6 mask0 readback", v, 32'h003F_FFFF);
    wr(12'h040, 32'h1234_5678);
    rd(12'h040, v); check("R6 mask1 readback", v, 32'h0034_5678);
    rd(12'h038, v); check("R6 clear reads zero", v, 32'd0);

    // R9: unmapped offsets
    wr(12'h044, 32'hFFFF_FFFF);
    wr(12'h000, 32'hFFFF_FFFF);
    wr(12'h03D, 32'h0);
    rd(12'h03C, v); check("R9 mask0 untouched", v, 32'h003F_FFFF);
    rd(12'h040, v); check("R9 mask1 untouched", v, 32'h0034_5678);
    rd(12'h034, v); check("R9 status untouched", v, 32'd0);
    rd(12'h044, v); check("R9 unmapped reads zero", v, 32'd0);
    rd(12'h036, v); check("R9 misaligned reads zero", v, 32'd0);
    rd(12'hFE1, v); check("R9 misaligned id reads zero", v, 32'd0);

    // R7: identification window
    for (int i = 0; i < 8; i++) begin
      logic [7:0] e;
      case (i)
        0: e = 8'h81; 1: e = 8'h11; 2: e = 8'h04; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      rd(12'hFE0 + 12'(4 * i), v); check("R7 id byte", v, {24'd0, e});
    end

    // R1: registered latency on mask 0
    wr(12'h040, 32'd0);
    wr(12'h03C, 32'h40);
    @(negedge clk); evt_set = 11'h040;
    @(negedge clk); evt_set = '0;
    check("R1 irq0 not yet high", {31'd0, irq_out[0]}, 32'd0);
    @(negedge clk);
    check("R1 irq0 high one cycle later", {31'd0, irq_out[0]}, 32'd1);
    wr(12'h038, 32'h40);
    check("R1 irq0 still high after clear edge", {31'd0, irq_out[0]}, 32'd1);
    @(negedge clk);
    check("R1 irq0 low after clear", {31'd0, irq_out[0]}, 32'd0);

    // R1: sweep masks over every status bit with a fixed pattern
    pulse(11'h0A5);
    @(negedge clk); live_flags = 11'h2C3;
    pat = {11'h2C3, 11'h0A5};
    for (int k = 0; k < 22; k++) begin
      wr(12'h03C, 32'd1 << k);
      wr(12'h040, ~(32'd1 << k));
      @(negedge clk);
      check("R1 irq0 single-bit mask", {31'd0, irq_out[0]}, {31'd0, pat[k]});
      check("R1 irq1 inverse mask", {31'd0, irq_out[1]}, {31'd0, |(pat & ~(22'd1 << k))});
    end

    // R8: reset mid-run
    @(negedge clk); live_flags = '0;
    wr(12'h03C, 32'h3F_FFFF);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R8 irq cleared by reset", {30'd0, irq_out}, 32'd0);
    check("R8 rdata cleared by reset", reg_rdata, 32'd0);
    rd(12'h034, v); check("R8 status cleared by reset", v, 32'd0);
    rd(12'h03C, v); check("R8 mask0 cleared by reset", v, 32'd0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule